// File: doc/BRIEF.md
# SPI Burst Transfer Engine

This block is the master-side sequencer of a multi-channel SPI controller. It reads 32-bit words from the read port of an external transmit FIFO and sends each word on the serial lines one byte at a time. The bytes that come back are packed into 32-bit words and written into an external receive FIFO. A burst is a programmed number of bits. A burst can be shorter than one word, or it can run across several words.

A transfer starts in one of two ways. In the first, it starts as soon as software writes a word into the transmit FIFO. In the second, it starts when the exchange bit goes from 0 to 1. A multi-burst mode keeps the exchange bit set while the transmit FIFO drains, and it reports only one transfer-complete event, at the very end. The active-low chip selects follow the channel-select field. The engine drives its transfer-complete and receive-overflow events as one-cycle pulses to a separate status unit.

Top module: `spi_burst_engine`

## Requirements
- R1: After a synchronous reset, `busy_o`, `xch_o`, `sclk_o` and `mosi_o` are 0 and no pulse appears on `done_o`, `ovf_o`, `tx_pop_o` or `rx_push_o`.
- R2: The selected channel is master when bit `chan_sel_i` of `chan_mode_i` is 1. While it is master, `cs_n_o[chan_sel_i]` is 0 and every other bit of `cs_n_o` is 1. While it is not master, all bits of `cs_n_o` are 1.
- R3: A burst has `len_m1_i`+1 bits. When a word is popped, a remaining-bit count that is 0 or below is first reloaded with this burst length. The word then carries min(count,32) bits, rounded up to whole bytes, and each byte sent takes 8 from the count.
- R4: The bytes of a word go out from byte 0 (bits 7:0) upward. Each byte is sent MSB first in SPI mode 0 (clock idles low, the receiver samples on the rising edge), as exactly 8 clock pulses. Each half period of the serial clock lasts `div_i`+1 system clocks.
- R5: The byte received during the exchange of byte k is stored at bits 8k+7:8k of the receive word. Bytes that are not sent read 0. The finished word is pushed with a one-cycle `rx_push_o`.
- R6: If `rx_full_i` is 1 when a finished word is ready, the word is dropped: `rx_push_o` stays 0 and `ovf_o` pulses for one cycle.
- R7: When `smc_i` is 1, a pulse on `tx_wr_i` starts the engine while it is idle and the channel is master. When the channel is not master, the pulse has no effect.
- R8: When `smc_i` is 0, a write of 1 to the exchange bit (`xch_wr_i` with `xch_val_i`=1) starts the engine only if the bit was 0 and the channel is master. A write of 1 to a bit that is already 1 does not start the engine.
- R9: Multi-burst mode applies when the channel is master, `smc_i` is 0 and bit `chan_sel_i` of `ss_ctl_i` is 1. In this mode `xch_o` stays 1 while words are sent, and no `done_o` pulse appears when a burst ends.
- R10: Outside multi-burst mode, `done_o` pulses after each word that leaves the remaining count at 0 or below. When the engine finds the transmit FIFO empty, it pulses `done_o`, clears `xch_o` and goes idle.
- R11: `busy_o` is 1 from the cycle after a start until the engine goes idle. A word is popped only after every byte of the previous word has been exchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| len_m1_i | input | LEN_W | Burst length in bits, minus one |
| chan_sel_i | input | SEL_W | Selected channel |
| chan_mode_i | input | CH | Per-channel master flags |
| ss_ctl_i | input | CH | Per-channel multi-burst enables |
| smc_i | input | 1 | 1: start on a transmit FIFO write; 0: start on the exchange bit |
| div_i | input | DIV_W | Serial clock half period, minus one, in system clocks |
| tx_wr_i | input | 1 | Pulse: a word was written into the transmit FIFO |
| xch_wr_i | input | 1 | Pulse: software writes the exchange bit |
| xch_val_i | input | 1 | Value written to the exchange bit |
| tx_empty_i | input | 1 | Transmit FIFO is empty |
| tx_data_i | input | 32 | Head word of the transmit FIFO |
| tx_pop_o | output | 1 | Pops the transmit FIFO |
| rx_full_i | input | 1 | Receive FIFO is full |
| rx_push_o | output | 1 | Pushes `rx_data_o` into the receive FIFO |
| rx_data_o | output | 32 | Assembled receive word |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | CH | Chip selects, active low |
| xch_o | output | 1 | Exchange bit |
| done_o | output | 1 | Transfer-complete pulse |
| ovf_o | output | 1 | Receive-overflow pulse |
| busy_o | output | 1 | Engine is active |

## Verification
Burst lengths of 32, 12 and 40 bits are used. The 32-bit case shows whether the byte order and the MSB-first order are right. The 12-bit case shows whether the count is reloaded on every word and whether unsent bytes are zeroed. The 40-bit case shows how the remaining count carries from one word into the next and where the `done_o` pulses fall. The slave returns the transmitted data either as it is (loopback) or inverted, so a byte stored in the wrong position, or a sample taken on the wrong edge, cannot match by chance. Separate sequences cover the following: the start on a FIFO write, the start on the exchange bit, a repeated write of 1 to the exchange bit, a non-master channel, multi-burst mode holding the exchange bit, and a full receive FIFO.

// File: rtl/spi_burst_pkg.sv
// Package: types shared by the SPI burst engine modules.
// Assumes: the FIFO word is 32 bits and is split into 8-bit exchanges.
package spi_burst_pkg;
    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int BYTES_PW = WORD_W / BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POP,
        ST_GO,
        ST_WAIT,
        ST_PUSH
    } eng_state_t;
endpackage

// File: rtl/spi_cs_decode.sv
// Chip-select decoder: drives the selected channel's line low while that
// channel is master. Every other line is held high.
// Assumes: the channel-select and master inputs are static configuration.
module spi_cs_decode #(
    parameter int CH    = 4,
    parameter int SEL_W = $clog2(CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             master_i,
    output logic [CH-1:0]    cs_n_o
);
    // one line per channel, low only for the selected master channel
    for (genvar g = 0; g < CH; g++) begin : g_cs
        assign cs_n_o[g] = !(master_i && (sel_i == SEL_W'(g)));
    end

    // R2
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o) && (master_i || (cs_n_o == {CH{1'b1}})));
endmodule

// File: rtl/spi_byte_shifter.sv
// Byte shifter: runs one 8-bit full-duplex exchange in SPI mode 0, MSB first.
// Each serial clock half period lasts div_i+1 system clocks.
// Assumes: start_i is given only while idle, and div_i is stable during a byte.
module spi_byte_shifter #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [7:0]       byte_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             miso_i,
    output logic             sclk_o,
    output logic             mosi_o,
    output logic             done_o,
    output logic [7:0]       byte_o
);
    logic             run_q, sclk_q, done_q;
    logic [DIV_W-1:0] cnt_q;
    logic [2:0]       bit_q;
    logic [7:0]       tsh_q, rsh_q;

    // half-period timing, sampling on the rising edge, shifting on the falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            bit_q  <= '0;
            tsh_q  <= '0;
            rsh_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (start_i && !run_q) begin
                run_q  <= 1'b1;
                sclk_q <= 1'b0;
                cnt_q  <= '0;
                bit_q  <= '0;
                tsh_q  <= byte_i;
            end else if (run_q) begin
                if (cnt_q == div_i) begin
                    cnt_q <= '0;
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                        rsh_q  <= {rsh_q[6:0], miso_i};
                    end else begin
                        sclk_q <= 1'b0;
                        tsh_q  <= {tsh_q[6:0], 1'b0};
                        if (bit_q == 3'd7) begin
                            run_q  <= 1'b0;
                            done_q <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 3'd1;
                        end
                    end
                end else begin
                    cnt_q <= cnt_q + DIV_W'(1);
                end
            end
        end
    end

    assign sclk_o = sclk_q;
    assign mosi_o = tsh_q[7];
    assign done_o = done_q;
    assign byte_o = rsh_q;

    // R4
    sclk_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_q) |-> ($past(cnt_q) == div_i));
endmodule

// File: rtl/spi_burst_ctrl.sv
// Burst controller: pops TX words, counts the burst in bits, runs the byte
// exchanges, packs the received bytes and pushes or drops the RX word.
// It also owns the exchange bit and the transfer-complete and overflow pulses.
// Assumes: the FIFO flags are updated within one cycle of a pop or push.
module spi_burst_ctrl
    import spi_burst_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  len_m1_i,
    input  logic              master_i,
    input  logic              multi_i,
    input  logic              smc_i,
    input  logic              tx_wr_i,
    input  logic              xch_wr_i,
    input  logic              xch_val_i,
    input  logic              tx_empty_i,
    input  logic [WORD_W-1:0] tx_data_i,
    output logic              tx_pop_o,
    input  logic              rx_full_i,
    output logic              rx_push_o,
    output logic [WORD_W-1:0] rx_data_o,
    output logic              xch_o,
    output logic              done_o,
    output logic              ovf_o,
    output logic              busy_o,
    output logic              sh_start_o,
    output logic [7:0]        sh_byte_o,
    input  logic              sh_done_i,
    input  logic [7:0]        sh_byte_i
);
    localparam int CNT_W = LEN_W + 2;

    eng_state_t               state_q;
    logic signed [CNT_W-1:0]  rem_q, rem_eff, burst_bits;
    logic [CNT_W-1:0]         r7;
    logic [2:0]               nb_q, nb_calc;
    logic [1:0]               idx_q;
    logic [WORD_W-1:0]        word_q, rxw_q;
    logic                     xch_q, start_go;

    // burst length, reload of the remaining count and bytes per word
    always_comb begin
        burst_bits = $signed({2'b00, len_m1_i}) + $signed(CNT_W'(1));
        rem_eff    = (rem_q <= 0) ? burst_bits : rem_q;
        r7         = CNT_W'(rem_eff) + CNT_W'(7);
        nb_calc    = (rem_eff >= 32) ? 3'(BYTES_PW) : r7[5:3];
    end

    // start on a TX write or on a 0-to-1 change of the exchange bit
    assign start_go = master_i && (smc_i ? tx_wr_i
                                         : (xch_wr_i && xch_val_i && !xch_q));

    // sequencer, exchange bit and word assembly
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
            nb_q    <= '0;
            idx_q   <= '0;
            word_q  <= '0;
            rxw_q   <= '0;
            xch_q   <= 1'b0;
        end else begin
            if (xch_wr_i) xch_q <= xch_val_i;
            case (state_q)
                ST_IDLE: if (start_go) state_q <= ST_POP;
                ST_POP: begin
                    if (tx_empty_i) begin
                        xch_q   <= 1'b0;
                        state_q <= ST_IDLE;
                    end else begin
                        word_q  <= tx_data_i;
                        rem_q   <= rem_eff;
                        nb_q    <= nb_calc;
                        idx_q   <= '0;
                        rxw_q   <= '0;
                        if (multi_i) xch_q <= 1'b1;
                        state_q <= ST_GO;
                    end
                end
                ST_GO: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (sh_done_i) begin
                        rxw_q[idx_q*8 +: 8] <= sh_byte_i;
                        rem_q <= rem_q - $signed(CNT_W'(8));
                        if ({1'b0, idx_q} == nb_q - 3'd1) begin
                            state_q <= ST_PUSH;
                        end else begin
                            idx_q   <= idx_q + 2'd1;
                            state_q <= ST_GO;
                        end
                    end
                end
                ST_PUSH: state_q <= ST_POP;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign tx_pop_o   = (state_q == ST_POP) && !tx_empty_i;
    assign rx_push_o  = (state_q == ST_PUSH) && !rx_full_i;
    assign ovf_o      = (state_q == ST_PUSH) && rx_full_i;
    assign done_o     = ((state_q == ST_PUSH) && (rem_q <= 0) && !multi_i) ||
                        ((state_q == ST_POP) && tx_empty_i);
    assign busy_o     = (state_q != ST_IDLE);
    assign rx_data_o  = rxw_q;
    assign xch_o      = xch_q;
    assign sh_start_o = (state_q == ST_GO);
    assign sh_byte_o  = word_q[idx_q*8 +: 8];

    // R11
    pop_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop_o |=> !tx_pop_o);

    // R3
    rem_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GO) |-> (rem_q > 0));

    // R9
    xch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (multi_i && (state_q == ST_WAIT)) |-> xch_q);

    // R10
    multi_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && multi_i) |-> tx_empty_i);
endmodule

// File: rtl/spi_burst_engine.sv
// SPI burst engine top: decodes the master and multi-burst conditions from the
// configuration and connects the controller, the byte shifter and the
// chip-select decoder.
// Assumes: the configuration inputs change only while busy_o is low.
module spi_burst_engine
    import spi_burst_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int CH    = 4,
    parameter int DIV_W = 8,
    parameter int SEL_W = $clog2(CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  len_m1_i,
    input  logic [SEL_W-1:0]  chan_sel_i,
    input  logic [CH-1:0]     chan_mode_i,
    input  logic [CH-1:0]     ss_ctl_i,
    input  logic              smc_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              tx_wr_i,
    input  logic              xch_wr_i,
    input  logic              xch_val_i,
    input  logic              tx_empty_i,
    input  logic [WORD_W-1:0] tx_data_i,
    output logic              tx_pop_o,
    input  logic              rx_full_i,
    output logic              rx_push_o,
    output logic [WORD_W-1:0] rx_data_o,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic [CH-1:0]     cs_n_o,
    output logic              xch_o,
    output logic              done_o,
    output logic              ovf_o,
    output logic              busy_o
);
    logic       master, multi, sh_start, sh_done;
    logic [7:0] sh_tx, sh_rx;

    // the master flag and the multi-burst condition of the selected channel
    assign master = chan_mode_i[chan_sel_i];
    assign multi  = master && !smc_i && ss_ctl_i[chan_sel_i];

    spi_burst_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .len_m1_i(len_m1_i),
        .master_i(master), .multi_i(multi), .smc_i(smc_i),
        .tx_wr_i(tx_wr_i), .xch_wr_i(xch_wr_i), .xch_val_i(xch_val_i),
        .tx_empty_i(tx_empty_i), .tx_data_i(tx_data_i), .tx_pop_o(tx_pop_o),
        .rx_full_i(rx_full_i), .rx_push_o(rx_push_o), .rx_data_o(rx_data_o),
        .xch_o(xch_o), .done_o(done_o), .ovf_o(ovf_o), .busy_o(busy_o),
        .sh_start_o(sh_start), .sh_byte_o(sh_tx),
        .sh_done_i(sh_done), .sh_byte_i(sh_rx)
    );

    spi_byte_shifter #(.DIV_W(DIV_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start_i(sh_start), .byte_i(sh_tx),
        .div_i(div_i), .miso_i(miso_i), .sclk_o(sclk_o), .mosi_o(mosi_o),
        .done_o(sh_done), .byte_o(sh_rx)
    );

    spi_cs_decode #(.CH(CH), .SEL_W(SEL_W)) u_cs (
        .clk(clk), .rst_n(rst_n), .sel_i(chan_sel_i), .master_i(master),
        .cs_n_o(cs_n_o)
    );
endmodule

// File: tb/spi_burst_engine_tb.sv
// Scoreboard bench: the driver tasks queue the TX words together with the
// bytes, RX words and pulse counts the requirements predict. The monitors
// compare them against what the design produces.
module spi_burst_engine_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] len_m1 = '0;
    logic [1:0]  chan_sel = '0;
    logic [3:0]  chan_mode = '0, ss_ctl = '0;
    logic        smc = 1'b0;
    logic [7:0]  div = 8'd1;
    logic        tx_wr = 1'b0, xch_wr = 1'b0, xch_val = 1'b0;
    logic        tx_empty = 1'b1, rx_full = 1'b0, inv = 1'b0;
    logic [31:0] tx_data = '0;
    logic        tx_pop, rx_push, sclk, mosi, miso, xch, done, ovf, busy;
    logic [31:0] rx_data;
    logic [3:0]  cs_n;

    int n_cmp = 0, n_err = 0;
    int exp_done = 0, exp_ovf = 0, act_done = 0, act_ovf = 0;
    int b_rem = 0, b_len = 0;
    bit b_multi = 0, pop_pend = 0, sclk_prev = 0;
    int bitcnt = 0, cyc = 0, last_rise = 0;
    logic [7:0]  cap;
    logic [31:0] txq[$];
    logic [7:0]  bq[$];
    logic [31:0] eq[$];

    assign miso = inv ? ~mosi : mosi;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_burst_engine u_dut (
        .clk(clk), .rst_n(rst_n), .len_m1_i(len_m1), .chan_sel_i(chan_sel),
        .chan_mode_i(chan_mode), .ss_ctl_i(ss_ctl), .smc_i(smc), .div_i(div),
        .tx_wr_i(tx_wr), .xch_wr_i(xch_wr), .xch_val_i(xch_val),
        .tx_empty_i(tx_empty), .tx_data_i(tx_data), .tx_pop_o(tx_pop),
        .rx_full_i(rx_full), .rx_push_o(rx_push), .rx_data_o(rx_data),
        .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n),
        .xch_o(xch), .done_o(done), .ovf_o(ovf), .busy_o(busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void refresh_tx();
        tx_empty = (txq.size() == 0);
        tx_data  = tx_empty ? 32'h0 : txq[0];
    endfunction

    // driver: queue one TX word and predict its bytes, RX word and pulses (R3 R5 R6 R10)
    task automatic queue_word(input logic [31:0] w);
        int nb;
        logic [31:0] rxw;
        if (b_rem <= 0) b_rem = b_len;
        nb  = (b_rem >= 32) ? 4 : (b_rem + 7) / 8;
        rxw = '0;
        for (int k = 0; k < nb; k++) begin
            bq.push_back(w[8*k +: 8]);
            rxw[8*k +: 8] = inv ? ~w[8*k +: 8] : w[8*k +: 8];
            b_rem -= 8;
        end
        if (rx_full) exp_ovf++;
        else eq.push_back(rxw);
        if (b_rem <= 0 && !b_multi) exp_done++;
        txq.push_back(w);
        refresh_tx();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        txq.delete(); bq.delete(); eq.delete();
        refresh_tx();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_done = 0; exp_ovf = 0; act_done = 0; act_ovf = 0;
        b_rem = 0; bitcnt = 0;
    endtask

    task automatic pulse_xch(input logic v);
        @(negedge clk);
        xch_wr = 1'b1; xch_val = v;
        @(negedge clk);
        xch_wr = 1'b0;
    endtask

    task automatic pulse_txwr();
        @(negedge clk);
        tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    // wait for the drain to end, then compare the counts and the leftovers (R10 R11)
    task automatic finish_run(input string tag);
        int lim = 0;
        while (busy && lim < 20000) begin @(negedge clk); lim++; end
        exp_done++;
        check({tag, " R10 done count"}, act_done, exp_done);
        check({tag, " R6 ovf count"}, act_ovf, exp_ovf);
        check({tag, " R10 xch cleared"}, {31'b0, xch}, 32'h0);
        check({tag, " R5 words left"}, eq.size(), 0);
        check({tag, " R4 bytes left"}, bq.size(), 0);
    endtask

    // monitor: TX pop, RX scoreboard, pulse counts, MOSI bytes and clock period
    always @(negedge clk) begin
        cyc++;
        if (pop_pend) begin
            void'(txq.pop_front());
            pop_pend = 0;
            refresh_tx();
        end
        if (tx_pop) pop_pend = 1;
        if (rst_n) begin
            if (done) act_done++;
            if (ovf) act_ovf++;
            if (rx_push) begin
                if (eq.size() == 0) check("R5 unexpected push", rx_data, 32'hx);
                else check("R5 rx word", rx_data, eq.pop_front());
                if (b_multi) check("R9 xch held", {31'b0, xch}, 32'h1);
            end
            if (sclk && !sclk_prev) begin
                if (bitcnt != 0) check("R4 sclk period", cyc - last_rise, 2 * (div + 1));
                last_rise = cyc;
                cap = {cap[6:0], mosi};
                bitcnt++;
                if (bitcnt == 8) begin
                    bitcnt = 0;
                    if (bq.size() == 0) check("R4 unexpected byte", {24'b0, cap}, 32'hx);
                    else check("R4 mosi byte", {24'b0, cap}, {24'b0, bq.pop_front()});
                end
            end
        end
        sclk_prev = sclk;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        check("R1 busy", {31'b0, busy}, 32'h0);
        check("R1 xch", {31'b0, xch}, 32'h0);
        check("R1 sclk/mosi", {30'b0, sclk, mosi}, 32'h0);
        check("R1 cs_n", {28'b0, cs_n}, 32'hF);

        // R2: master channel 2 selected, then a non-master channel
        chan_mode = 4'b0100; chan_sel = 2'd2;
        @(negedge clk);
        check("R2 cs master", {28'b0, cs_n}, 32'hB);
        chan_sel = 2'd1;
        @(negedge clk);
        check("R2 cs non-master", {28'b0, cs_n}, 32'hF);

        // R8: no start for a non-master channel, or for a write of 1 over 1
        len_m1 = 12'd31; b_len = 32;
        pulse_xch(1'b1);
        check("R8 non-master no start", {31'b0, busy}, 32'h0);
        chan_sel = 2'd2;
        queue_word(32'hA1B2C3D4);
        pulse_xch(1'b1);
        repeat (3) @(negedge clk);
        check("R8 1-to-1 no start", {31'b0, busy}, 32'h0);
        pulse_xch(1'b0);
        pulse_xch(1'b1);
        check("R11 busy after start", {31'b0, busy}, 32'h1);
        finish_run("32-bit");

        // R3 R5: 12-bit bursts, inverted slave, slower clock
        do_reset();
        chan_mode = 4'b0100; chan_sel = 2'd2; div = 8'd2; inv = 1'b1;
        len_m1 = 12'd11; b_len = 12;
        queue_word(32'h11223344);
        queue_word(32'hCAFEBABE);
        pulse_xch(1'b1);
        finish_run("12-bit");

        // R3 R10: a 40-bit burst carried across words
        do_reset();
        div = 8'd1; inv = 1'b0; len_m1 = 12'd39; b_len = 40;
        queue_word(32'h01020304);
        queue_word(32'h55667788);
        queue_word(32'h99AABBCC);
        pulse_xch(1'b1);
        finish_run("40-bit");

        // R7: start on a TX write; a non-master channel ignores it
        do_reset();
        smc = 1'b1; len_m1 = 12'd15; b_len = 16; chan_sel = 2'd0;
        pulse_txwr();
        check("R7 non-master no start", {31'b0, busy}, 32'h0);
        check("R7 no done", act_done, 0);
        chan_sel = 2'd2;
        queue_word(32'hDEADBEEF);
        queue_word(32'h0BADF00D);
        pulse_txwr();
        check("R7 started", {31'b0, busy}, 32'h1);
        finish_run("smc");

        // R9: multi-burst mode keeps the exchange bit and reports done only at the end
        do_reset();
        smc = 1'b0; ss_ctl = 4'b0100; b_multi = 1; len_m1 = 12'd7; b_len = 8;
        queue_word(32'h000000A5);
        queue_word(32'h0000005A);
        pulse_xch(1'b1);
        finish_run("multi");
        b_multi = 0; ss_ctl = '0;

        // R6: a full receive FIFO drops the word and raises overflow
        do_reset();
        rx_full = 1'b1;
        queue_word(32'h12345678);
        pulse_xch(1'b1);
        finish_run("ovf");
        rx_full = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule